// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block holds the time of day and the calendar as packed BCD fields: seconds, minutes, hours, a day-of-week counter, date, month and a two-digit year. A per-cycle enable input is divided down by a parameterised sub-second counter. Each time that counter completes, the calendar advances by one second. Carries ripple through minutes, hours, days, months and years in the same cycle.

The hours register runs either as a 24-hour count or as a 12-hour count with a PM flag. Bit 6 of the hours register selects the mode. Month lengths follow the calendar, and February gains a 29th day in years divisible by four. Bit 7 of the seconds register is a halt flag that freezes the counter.

A bus interface (not part of this block) loads any field through a single-cycle write port. Out-of-range values are accepted as written, and counting continues from them without correction.

Top module: `rtc_calendar_core`

## Requirements
- R1: A write with `wr_en`=1 loads `wr_data` into the field selected by `wr_addr` at the next clock edge. The addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. Only the meaningful low bits are kept: 8 for seconds, 7 for minutes and hours, 3 for day of week, 6 for date, 5 for month and 8 for year; unused bits read 0. Address 7 changes nothing. In a write cycle, `tick_en` is ignored and no field counts.
- R2: Seconds and minutes count BCD 00 to 59. From 59 they return to 00 and carry into the next field.
- R3: While bit 7 of seconds is 1, no field changes and the sub-second count is frozen; only a write changes state.
- R4: One second elapses after `TICKS_PER_SEC` cycles with `tick_en`=1 while running and not writing. Writing the seconds register clears the sub-second count, so the next step needs a full `TICKS_PER_SEC` enables.
- R5: With hours bit 6 = 0, hours count BCD 00 to 23 in bits 5:0. The step from 23 to 00 ends the day.
- R6: With hours bit 6 = 1, bits 4:0 run 12, 01, 02 … 11 and bit 5 is PM. The step from 11 to 12 toggles PM, and when that step leaves PM it ends the day. Bit 6 is kept.
- R7: At each day end the day of week steps by one. From 7 it goes to 1, and from 0 it goes to 1.
- R8: At a day end the date goes to 01 when it equals the month's last date: 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. Otherwise the date counts up in BCD.
- R9: For month 02 the last date is 29 when the year's BCD value (tens×10 + units) is divisible by 4, and 28 otherwise.
- R10: A date rollover in month 12 sets the month to 01 and steps the year. Year 99 goes to 00.
- R11: Reset (`rst_n`=0 at a clock edge) loads seconds 0x80 (halted), minutes 00, hours 00 (24-hour mode), day of week 1, date 01, month 01 and year 00.
- R12: Out-of-range values are not corrected. A step on a BCD field whose units digit is 9 or more clears the units digit and adds one to the tens digit. Any other non-terminal value adds one. Example: minutes 0x5A becomes 0x60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Sub-second enable, one count per cycle when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Field select for a write |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Halt flag (bit 7) and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Mode bit 6, PM/tens bit 5, BCD hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | BCD date |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The bench builds the block with `TICKS_PER_SEC` = 3, so one second takes only three enabled cycles. At that rate, a divider clear in the middle of a second, and the first step after it, can be observed directly.

Loading values just short of a boundary brings the rare events into a few cycles: a midnight rollover, a month end, a leap February, the last day of the year, and both 12-hour transitions. A long random run mixes enables, halts and arbitrary writes. A behavioural model checks every field on every cycle during that run.

// File: rtl/rtc_cal_pkg.sv
// Shared field addresses and the BCD step function for the calendar counter.
package rtc_cal_pkg;
    localparam logic [2:0] ADDR_SEC  = 3'd0;
    localparam logic [2:0] ADDR_MIN  = 3'd1;
    localparam logic [2:0] ADDR_HOUR = 3'd2;
    localparam logic [2:0] ADDR_DOW  = 3'd3;
    localparam logic [2:0] ADDR_DATE = 3'd4;
    localparam logic [2:0] ADDR_MON  = 3'd5;
    localparam logic [2:0] ADDR_YEAR = 3'd6;

    // Advance a packed BCD byte by one; a units digit of 9 or more carries.
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction
endpackage

// File: rtl/rtc_subsec_div.sv
// Sub-second divider: counts enabled cycles and flags the one that completes
// a second. Assumes halt, hold and clear are synchronous to clk; clear implies hold.
module rtc_subsec_div #(
    parameter int unsigned TICKS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic halt,
    input  logic hold,
    input  logic clear,
    output logic step
);
    localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          advance;

    assign advance = tick_en & ~halt & ~hold;
    assign step    = advance & (cnt_q == LAST);

    // Count enables, wrap at the last one, clear on a seconds write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (advance)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // R4
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

    // R3
    div_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_hour_next.sv
// Next-hour logic for both hour encodings. Input is the stored 7-bit hours
// field; output is its successor and whether that step ends the day.
module rtc_hour_next
    import rtc_cal_pkg::*;
(
    input  logic [6:0] hour_in,
    output logic [6:0] hour_nx,
    output logic       day_end
);
    logic [7:0] inc12;
    logic [7:0] inc24;
    logic       pm;

    assign pm    = hour_in[5];
    assign inc12 = bcd_step({3'b000, hour_in[4:0]});
    assign inc24 = bcd_step({2'b00, hour_in[5:0]});

    // Choose the 12-hour or 24-hour successor.
    always_comb begin
        day_end = 1'b0;
        if (hour_in[6]) begin
            if (hour_in[4:0] == 5'h12) begin
                hour_nx = {1'b1, pm, 5'h01};
            end else if (hour_in[4:0] == 5'h11) begin
                hour_nx = {1'b1, ~pm, 5'h12};
                day_end = pm;
            end else begin
                hour_nx = {1'b1, pm, inc12[4:0]};
            end
        end else begin
            if (hour_in[5:0] == 6'h23) begin
                hour_nx = 7'h00;
                day_end = 1'b1;
            end else begin
                hour_nx = {1'b0, inc24[5:0]};
            end
        end
    end
endmodule

// File: rtl/rtc_month_len.sv
// Last valid date of the current month in BCD, with February leap handling.
// Assumes a BCD year; leap when tens*10+units is divisible by four.
module rtc_month_len (
    input  logic [4:0] month,
    input  logic [7:0] year,
    output logic [5:0] last_date
);
    logic [1:0] mod4;
    logic       leap;

    // (10*t + u) mod 4 == (u + 2*t) mod 4, so only t's parity matters.
    assign mod4 = year[1:0] + {year[4], 1'b0};
    assign leap = (mod4 == 2'd0);

    // Map the month code to its length.
    always_comb begin
        case (month)
            5'h02:                      last_date = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
            default:                    last_date = 6'h31;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_core.sv
// BCD clock-calendar counter. Holds the time and date fields. It advances one
// second per TICKS_PER_SEC enabled cycles unless halted, and takes single-cycle
// writes. Assumes tick_en and the write port are synchronous to clk.
// Writes have priority over counting.
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);
    logic [7:0] sec_q;
    logic [6:0] min_q;
    logic [6:0] hour_q;
    logic [2:0] dow_q;
    logic [5:0] date_q;
    logic [4:0] mon_q;
    logic [7:0] year_q;

    logic       step;
    logic [6:0] hour_nx;
    logic       hour_day_end;
    logic [5:0] last_date;
    logic       sec_wrap, min_wrap;
    logic       min_step, hour_step, day_step, mon_step, year_step;
    logic [7:0] sec_inc, min_inc, date_inc, mon_inc, year_inc;

    rtc_subsec_div #(.TICKS(TICKS_PER_SEC)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .halt    (sec_q[7]),
        .hold    (wr_en),
        .clear   (wr_en && (wr_addr == ADDR_SEC)),
        .step    (step)
    );

    rtc_hour_next u_hour (
        .hour_in (hour_q),
        .hour_nx (hour_nx),
        .day_end (hour_day_end)
    );

    rtc_month_len u_mlen (
        .month     (mon_q),
        .year      (year_q),
        .last_date (last_date)
    );

    assign sec_wrap  = (sec_q[6:0] == 7'h59);
    assign min_wrap  = (min_q == 7'h59);
    assign min_step  = step & sec_wrap;
    assign hour_step = min_step & min_wrap;
    assign day_step  = hour_step & hour_day_end;
    assign mon_step  = day_step & (date_q == last_date);
    assign year_step = mon_step & (mon_q == 5'h12);

    assign sec_inc  = bcd_step({1'b0, sec_q[6:0]});
    assign min_inc  = bcd_step({1'b0, min_q});
    assign date_inc = bcd_step({2'b00, date_q});
    assign mon_inc  = bcd_step({3'b000, mon_q});
    assign year_inc = bcd_step(year_q);

    // Load a written field or ripple the one-second step through the fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= 8'h80;
            min_q  <= 7'h00;
            hour_q <= 7'h00;
            dow_q  <= 3'd1;
            date_q <= 6'h01;
            mon_q  <= 5'h01;
            year_q <= 8'h00;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_SEC:  sec_q  <= wr_data;
                ADDR_MIN:  min_q  <= wr_data[6:0];
                ADDR_HOUR: hour_q <= wr_data[6:0];
                ADDR_DOW:  dow_q  <= wr_data[2:0];
                ADDR_DATE: date_q <= wr_data[5:0];
                ADDR_MON:  mon_q  <= wr_data[4:0];
                ADDR_YEAR: year_q <= wr_data;
                default: ;
            endcase
        end else if (step) begin
            sec_q <= sec_wrap ? 8'h00 : {1'b0, sec_inc[6:0]};
            if (min_step)
                min_q <= min_wrap ? 7'h00 : min_inc[6:0];
            if (hour_step)
                hour_q <= hour_nx;
            if (day_step) begin
                dow_q  <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
                date_q <= (date_q == last_date) ? 6'h01 : date_inc[5:0];
            end
            if (mon_step)
                mon_q <= (mon_q == 5'h12) ? 5'h01 : mon_inc[4:0];
            if (year_step)
                year_q <= (year_q == 8'h99) ? 8'h00 : year_inc;
        end
    end

    assign sec_o   = sec_q;
    assign min_o   = {1'b0, min_q};
    assign hour_o  = {1'b0, hour_q};
    assign dow_o   = {5'b0, dow_q};
    assign date_o  = {2'b0, date_q};
    assign month_o = {3'b0, mon_q};
    assign year_o  = year_q;

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[7] && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)
            && $stable(dow_q) && $stable(date_q) && $stable(mon_q) && $stable(year_q)));

    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sec_wrap) |=> (sec_q == 8'h00));

    // R7
    dow_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        day_step |=> (dow_q == (($past(dow_q) == 3'd7) ? 3'd1 : $past(dow_q) + 3'd1)));

    // R6
    pm_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_step && hour_q[6] && hour_q[4:0] == 5'h11) |=> (hour_q[5] != $past(hour_q[5])));

    // R10
    year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (year_step && year_q == 8'h99) |=> (year_q == 8'h00));
endmodule

// File: tb/tb_rtc_calendar_core.sv
// Bench: behavioural calendar model compared on every clock, plus directed
// boundary checks with hand-computed values.
module tb_rtc_calendar_core;
    localparam int T = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

    int checks = 0;
    int fails = 0;
    int cyc_cnt = 0;
    bit done = 0;

    int m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_year, m_div;

    always #5 clk = ~clk;

    rtc_calendar_core #(.TICKS_PER_SEC(T)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int binc(input int v, input int w);
        int lo = v % 16;
        int hi = v / 16;
        if (lo >= 9) begin lo = 0; hi++; end else lo++;
        return (hi * 16 + lo) % (1 << w);
    endfunction

    function automatic int mlast(input int mon, input int yr);
        int y = (yr / 16) * 10 + (yr % 16);
        if (mon == 'h02) return (y % 4 == 0) ? 'h29 : 'h28;
        if (mon == 'h04 || mon == 'h06 || mon == 'h09 || mon == 'h11) return 'h30;
        return 'h31;
    endfunction

    task automatic model_reset();
        m_sec = 'h80; m_min = 0; m_hour = 0; m_dow = 1;
        m_date = 1; m_mon = 1; m_year = 0; m_div = 0;
    endtask

    task automatic model_second();
        bit c;
        int f, pm, s;
        s = m_sec & 127;
        c = (s == 'h59);
        m_sec = c ? 0 : binc(s, 7);
        if (!c) return;
        c = (m_min == 'h59);
        m_min = c ? 0 : binc(m_min, 7);
        if (!c) return;
        c = 0;
        if (m_hour & 64) begin
            f = m_hour & 31; pm = (m_hour >> 5) & 1;
            if (f == 'h12) f = 1;
            else if (f == 'h11) begin f = 'h12; c = (pm == 1); pm = 1 - pm; end
            else f = binc(f, 5);
            m_hour = 64 + pm * 32 + f;
        end else if (m_hour == 'h23) begin
            m_hour = 0; c = 1;
        end else m_hour = binc(m_hour, 6);
        if (!c) return;
        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
        if (m_date != mlast(m_mon, m_year)) begin
            m_date = binc(m_date, 6);
            return;
        end
        m_date = 1;
        if (m_mon != 'h12) begin m_mon = binc(m_mon, 5); return; end
        m_mon = 1;
        m_year = (m_year == 'h99) ? 0 : binc(m_year, 8);
    endtask

    task automatic model_cycle(input bit tk, input bit we, input int a, input int d);
        if (we) begin
            case (a)
                0: begin m_sec = d; m_div = 0; end
                1: m_min = d & 'h7f;
                2: m_hour = d & 'h7f;
                3: m_dow = d & 7;
                4: m_date = d & 'h3f;
                5: m_mon = d & 'h1f;
                6: m_year = d;
                default: ;
            endcase
        end else if (tk && !(m_sec & 'h80)) begin
            if (m_div == T - 1) begin m_div = 0; model_second(); end
            else m_div++;
        end
    endtask

    task automatic compare_all();
        chk("R2 seconds", sec_o, m_sec);
        chk("R2 minutes", min_o, m_min);
        chk("R5 hours", hour_o, m_hour);
        chk("R7 dow", dow_o, m_dow);
        chk("R8 date", date_o, m_date);
        chk("R10 month", month_o, m_mon);
        chk("R10 year", year_o, m_year);
    endtask

    // One clock: drive, update model, sample at the following falling edge.
    task automatic cyc(input bit tk, input bit we, input int a, input int d);
        tick_en = tk; wr_en = we; wr_addr = 3'(a); wr_data = 8'(d);
        model_cycle(tk, we, a, d);
        @(posedge clk);
        @(negedge clk);
        tick_en = 0; wr_en = 0;
        compare_all();
    endtask

    task automatic wr(input int a, input int d);
        cyc(0, 1, a, d);
    endtask

    task automatic one_sec();
        repeat (T) cyc(1, 0, 0, 0);
    endtask

    task automatic set_time(input int h, input int mi, input int s);
        wr(2, h); wr(1, mi); wr(0, s);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 150000) begin
                checks++; fails++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc_cnt);
                finish_run();
            end
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R11 reset values
        chk("R11 sec", sec_o, 'h80);
        chk("R11 min", min_o, 0);
        chk("R11 hour", hour_o, 0);
        chk("R11 dow", dow_o, 1);
        chk("R11 date", date_o, 1);
        chk("R11 month", month_o, 1);
        chk("R11 year", year_o, 0);
        rst_n = 1;

        // R3 halted after reset
        repeat (10) cyc(1, 0, 0, 0);
        chk("R3 halted", sec_o, 'h80);

        // R4 exactly T enables per second
        wr(0, 'h00);
        repeat (T - 1) cyc(1, 0, 0, 0);
        chk("R4 before step", sec_o, 'h00);
        cyc(1, 0, 0, 0);
        chk("R4 step", sec_o, 'h01);

        // R4 seconds write clears the divider
        repeat (T - 1) cyc(1, 0, 0, 0);
        wr(0, 'h10);
        repeat (T - 1) cyc(1, 0, 0, 0);
        chk("R4 cleared", sec_o, 'h10);
        cyc(1, 0, 0, 0);
        chk("R4 full second", sec_o, 'h11);

        // R1 write wins over a completing tick
        repeat (T - 1) cyc(1, 0, 0, 0);
        cyc(1, 1, 1, 'h07);
        chk("R1 tick ignored on write", sec_o, 'h11);
        chk("R1 minutes written", min_o, 'h07);
        // R1 address 7 changes nothing
        cyc(0, 1, 7, 'hff);
        chk("R1 addr7 sec", sec_o, 'h11);
        chk("R1 addr7 min", min_o, 'h07);
        chk("R1 addr7 year", year_o, 'h00);
        // R1 masking of unused bits
        wr(3, 'hfd);
        chk("R1 dow mask", dow_o, 'h05);

        // R5 R7 R8 R10 end of year in 24-hour mode
        wr(6, 'h99); wr(5, 'h12); wr(4, 'h31); wr(3, 7);
        set_time('h23, 'h59, 'h59);
        one_sec();
        chk("R2 sec wrap", sec_o, 'h00);
        chk("R2 min wrap", min_o, 'h00);
        chk("R5 hour wrap", hour_o, 'h00);
        chk("R7 dow 7 to 1", dow_o, 1);
        chk("R8 date wrap", date_o, 'h01);
        chk("R10 month wrap", month_o, 'h01);
        chk("R10 year wrap", year_o, 'h00);

        // R9 leap February
        wr(6, 'h24); wr(5, 'h02); wr(4, 'h28);
        set_time('h23, 'h59, 'h59);
        one_sec();
        chk("R9 leap 29th", date_o, 'h29);
        set_time('h23, 'h59, 'h59);
        one_sec();
        chk("R9 leap to March date", date_o, 'h01);
        chk("R9 leap to March month", month_o, 'h03);
        // R9 common year
        wr(6, 'h23); wr(5, 'h02); wr(4, 'h28);
        set_time('h23, 'h59, 'h59);
        one_sec();
        chk("R9 common date", date_o, 'h01);
        chk("R9 common month", month_o, 'h03);

        // R8 thirty- and thirty-one-day months
        wr(5, 'h04); wr(4, 'h30);
        set_time('h23, 'h59, 'h59);
        one_sec();
        chk("R8 april end", month_o, 'h05);
        wr(5, 'h01); wr(4, 'h30);
        set_time('h23, 'h59, 'h59);
        one_sec();
        chk("R8 january 31st", date_o, 'h31);

        // R6 12-hour: 11 AM to 12 PM, no day change
        wr(3, 3); wr(4, 'h10); wr(5, 'h06);
        set_time('h51, 'h59, 'h59);
        one_sec();
        chk("R6 noon", hour_o, 'h72);
        chk("R6 noon dow", dow_o, 3);
        // R6 11 PM to 12 AM ends the day
        set_time('h71, 'h59, 'h59);
        one_sec();
        chk("R6 midnight", hour_o, 'h52);
        chk("R6 midnight dow", dow_o, 4);
        chk("R6 midnight date", date_o, 'h11);
        // R6 12 to 01
        set_time('h52, 'h59, 'h59);
        one_sec();
        chk("R6 twelve to one", hour_o, 'h41);

        // R12 out-of-range minutes and day of week
        set_time('h05, 'h5a, 'h59);
        one_sec();
        chk("R12 minutes 5A", min_o, 'h60);
        wr(3, 0);
        set_time('h23, 'h59, 'h59);
        one_sec();
        chk("R12 dow 0 to 1", dow_o, 1);

        // R3 halt mid-run with a nonzero count
        wr(0, 'h85);
        repeat (20) cyc(1, 0, 0, 0);
        chk("R3 halt sec", sec_o, 'h85);
        chk("R3 halt min", min_o, 'h00);

        // Random run compared against the model every cycle
        for (int i = 0; i < 20000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 4) begin
                int a = $urandom_range(0, 7);
                int d = $urandom_range(0, 255);
                if (a == 0 && $urandom_range(0, 3) != 0) d = d & 'h7f;
                if ($urandom_range(0, 3) != 0) begin
                    case (a)
                        0: d = {$urandom_range(0, 5), 4'(0)} + $urandom_range(0, 9);
                        1: d = {$urandom_range(0, 5), 4'(0)} + $urandom_range(0, 9);
                        2: d = ($urandom_range(0, 1) == 1) ? ('h40 + 'h11 + 32 * $urandom_range(0, 1)) : 'h23;
                        4: d = 'h28 + $urandom_range(0, 1) * 2;
                        5: d = $urandom_range(1, 9);
                        default: ;
                    endcase
                end
                cyc(0, 1, a, d);
            end else begin
                cyc(r < 85, 0, 0, 0);
            end
        end
        finish_run();
    end
endmodule